// File: doc/BRIEF.md
# Serial Host Register Port

This block is a slave-side serial port through which a host processor reaches the 8-bit register file of a line-interface device. The host uses four wires: an active-low chip select, a serial clock, a data input and a data output. Each access is one frame of 16 bits on the data input. The first byte holds the direction flag and a 6-bit register address. The second byte holds the write data. On a read, the register contents return on the data output while the host clocks the second byte.

All four serial wires are oversampled in the core clock domain through a synchronizer. Edges of the serial clock and of chip select are then turned into single-cycle events. The register file sits outside the block. It sees a one-cycle read strobe or write strobe together with an address and write data, and it returns read data combinationally for the presented address. The data output comes with a separate enable, so the pad can drive high impedance. A static pin selects which serial clock edge launches read data.

Top module: `shp_host_port`

## Requirements
- R1: A frame starts when chip select falls. The bit counter restarts from zero at that point, whatever happened in earlier frames.
- R2: Input bits are sampled on rising serial clock edges and sent least significant bit first. Frame bit 0 is the direction flag (1 = read). Bits 1..6 are the register address, with bit 1 as its LSB. Bit 7 is reserved and has no effect. Bits 8..15 are the write data, with bit 8 as its LSB.
- R3: A write frame produces exactly one write strobe of one core clock cycle. It comes one cycle after the 16th bit has been captured, and it carries the frame's address and data.
- R4: A read frame produces a one-cycle read strobe with the frame's address once the 8th bit is captured. The returned register byte is loaded into the output shifter in that cycle.
- R5: Read data is sent on the data output least significant bit first. Bit k is valid at the (9+k)-th serial clock cycle of the frame.
- R6: With the edge-select pin high, read data changes after falling serial clock edges, so bit k is valid at the (9+k)-th rising edge.
- R7: With the edge-select pin low, read data changes after rising serial clock edges, so bit k is valid at the (9+k)-th falling edge.
- R8: The data output enable is low whenever chip select is high.
- R9: The data output enable stays low for the whole of a write frame.
- R10: If chip select rises before 16 bits have arrived, the frame is dropped and no write strobe is issued.
- R11: Serial clock edges after the 16th bit, while chip select is still low, are ignored. They cause no further strobes.
- R12: After reset, both strobes and the output enable are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from host |
| sdi_i | input | 1 | Serial data from host |
| edge_sel_i | input | 1 | 1: read data valid on rising SCLK, 0: on falling |
| sdo_o | output | 1 | Serial read data |
| sdo_oe_o | output | 1 | Output enable for the data pad |
| reg_addr_o | output | 6 | Register address |
| reg_wdata_o | output | 8 | Register write data |
| reg_we_o | output | 1 | Write strobe, one cycle |
| reg_re_o | output | 1 | Read strobe, one cycle |
| reg_rdata_i | input | 8 | Register read data for reg_addr_o |

## Verification
The hardest case to reach from the ports is the timing of read data against the launch edge. Because of the synchronizer, a wrong edge choice only shows up as a bit that is one position late when sampled at exactly the valid edge. The bench therefore samples each returned bit just before it toggles the serial clock edge that the host would use. It runs reads in both edge-select settings, reading back register contents that earlier write frames placed there. Aborted frames, over-long frames and a set reserved bit are driven as whole frames, and their effect is then observed through later reads and strobe counts.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_CMD  = 2'd1,
    PH_DATA = 2'd2,
    PH_DONE = 2'd3
  } shp_phase_e;
endpackage

// File: rtl/shp_sync.sv
module shp_sync #(
  parameter int          WIDTH   = 3,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= {STAGES{RST_VAL}};
    else         stage_q <= {stage_q[STAGES-2:0], d_i};
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/shp_frame.sv
module shp_frame
  import shp_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              cs_fall_i,
  input  logic              sclk_rise_i,
  input  logic              sdi_i,
  output shp_phase_e        phase_o,
  output logic [$clog2(ADDR_W+2+DATA_W+1)-1:0] cnt_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              re_o
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_CMD_LAST = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST     = CNT_W'(FRAME - 1);
  localparam logic [CNT_W-1:0] CNT_FULL     = CNT_W'(FRAME);

  logic [FRAME-1:0] sr_q, sr_nxt;
  logic             shifting;

  assign sr_nxt   = {sdi_i, sr_q[FRAME-1:1]};
  assign shifting = cs_act_i && sclk_rise_i &&
                    (phase_o == PH_CMD || phase_o == PH_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_o <= PH_IDLE;
      cnt_o   <= '0;
      sr_q    <= '0;
      rd_o    <= 1'b0;
      addr_o  <= '0;
      wdata_o <= '0;
      we_o    <= 1'b0;
      re_o    <= 1'b0;
    end else begin
      we_o <= 1'b0;
      re_o <= 1'b0;
      if (cs_fall_i) begin
        phase_o <= PH_CMD;
        cnt_o   <= '0;
        rd_o    <= 1'b0;
      end else if (!cs_act_i) begin
        phase_o <= PH_IDLE;
      end else if (shifting) begin
        sr_q  <= sr_nxt;
        cnt_o <= cnt_o + 1'b1;
        if (cnt_o == CNT_CMD_LAST) begin
          // command byte sits in the top CMD_W bits; reserved bit dropped
          phase_o <= PH_DATA;
          rd_o    <= sr_nxt[DATA_W];
          addr_o  <= sr_nxt[DATA_W+1 +: ADDR_W];
          re_o    <= sr_nxt[DATA_W];
        end
        if (cnt_o == CNT_LAST) begin
          phase_o <= PH_DONE;
          wdata_o <= sr_nxt[FRAME-1 -: DATA_W];
          we_o    <= !rd_o;
        end
      end
    end
  end

  a_r3_we_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !we_o);
  a_r4_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_o && re_o));
  a_r10_we_full_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (cnt_o == CNT_FULL && phase_o == PH_DONE));
  a_r11_cnt_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o <= CNT_FULL);
endmodule

// File: rtl/shp_dout.sv
module shp_dout #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_sel_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              shift_en_i,
  input  logic              oe_en_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  logic [DATA_W-1:0] out_sr_q;
  logic              launch;

  // edge_sel high: host samples on rise, so advance on fall
  assign launch = shift_en_i && (edge_sel_i ? sclk_fall_i : sclk_rise_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_sr_q <= '0;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_oe_o <= oe_en_i;
      if (load_i)      out_sr_q <= load_data_i;
      else if (launch) out_sr_q <= {1'b0, out_sr_q[DATA_W-1:1]};
    end
  end

  assign sdo_o = out_sr_q[0];

  a_r4_load_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (sdo_o == $past(load_data_i[0])));
  // R6 and R7: data only moves on the selected launch edge
  a_r6_hold_between_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!launch && !load_i) |=> $stable(sdo_o));
endmodule

// File: rtl/shp_host_port.sv
module shp_host_port
  import shp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              edge_sel_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o,
  output logic              reg_re_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  localparam int CMD_W = ADDR_W + 2;
  localparam int FRAME = CMD_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME + 1);
  localparam logic [CNT_W-1:0] CNT_OUT_FIRST = CNT_W'(CMD_W + 1);

  logic [2:0]       sync_q;
  logic             cs_n_s, sclk_s, sdi_s;
  logic             cs_n_d, sclk_d;
  logic             cs_act, cs_fall, sclk_rise, sclk_fall;
  shp_phase_e       phase;
  logic [CNT_W-1:0] cnt;
  logic             rd_q, out_phase, shift_en, oe_en;

  shp_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cs_ni, sclk_i, sdi_i}),
    .q_o   (sync_q)
  );
  assign {cs_n_s, sclk_s, sdi_s} = sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_d <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_n_d <= cs_n_s;
      sclk_d <= sclk_s;
    end
  end

  assign cs_act    = !cs_n_s;
  assign cs_fall   = cs_n_d && !cs_n_s;
  assign sclk_rise = !sclk_d && sclk_s;
  assign sclk_fall = sclk_d && !sclk_s;

  shp_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .cs_fall_i  (cs_fall),
    .sclk_rise_i(sclk_rise),
    .sdi_i      (sdi_s),
    .phase_o    (phase),
    .cnt_o      (cnt),
    .rd_o       (rd_q),
    .addr_o     (reg_addr_o),
    .wdata_o    (reg_wdata_o),
    .we_o       (reg_we_o),
    .re_o       (reg_re_o)
  );

  assign out_phase = (phase == PH_DATA) || (phase == PH_DONE);
  assign oe_en     = cs_act && rd_q && out_phase;
  assign shift_en  = oe_en && (cnt >= CNT_OUT_FIRST);

  shp_dout #(.DATA_W(DATA_W)) u_dout (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .edge_sel_i (edge_sel_i),
    .sclk_rise_i(sclk_rise),
    .sclk_fall_i(sclk_fall),
    .load_i     (reg_re_o),
    .load_data_i(reg_rdata_i),
    .shift_en_i (shift_en),
    .oe_en_i    (oe_en),
    .sdo_o      (sdo_o),
    .sdo_oe_o   (sdo_oe_o)
  );

  a_r8_oe_off_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act && !$past(cs_act)) |-> !sdo_oe_o);
  a_r9_oe_only_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> rd_q);
  a_r1_restart_on_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (cnt == '0 && phase == PH_CMD));
endmodule

// File: tb/tb_shp_host_port.sv
module tb_shp_host_port;
  localparam int H = 8;
  localparam int NV = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, esel = 1'b0;
  logic       sdo, sdo_oe, we, re;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;

  logic [7:0] mem [64];
  logic [7:0] exp_mem [64];
  int checks = 0, failures = 0;
  int we_cnt = 0, re_cnt = 0, oe_bad_wr = 0, oe_bad_cs = 0;
  bit in_write = 0, finished = 0;

  always #2.5 clk = ~clk;

  shp_host_port dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .edge_sel_i(esel), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .reg_addr_o(addr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_re_o(re), .reg_rdata_i(rdata)
  );

  assign rdata = mem[addr];

  int cs_hi_run = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 8'h00;
    end else begin
      if (we) begin mem[addr] <= wdata; we_cnt++; end
      if (re) re_cnt++;
      if (in_write && sdo_oe) oe_bad_wr++;
      cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
      if (cs_hi_run > 4 && sdo_oe) oe_bad_cs++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // frame: bit0 rd, bits1..6 addr, bit7 reserved, bits8..15 data, LSB first
  task automatic xfer(input bit rd, input bit rsvd, input logic [5:0] a,
                      input logic [7:0] d, input bit es, input int nbits);
    logic [15:0] word;
    logic [7:0]  expd;
    word = {d, rsvd, a, rd};
    expd = exp_mem[a];
    @(negedge clk);
    esel = es;
    in_write = !rd;
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? word[i] : 1'b1;
      repeat (H) @(negedge clk);
      if (rd && es && i >= 8 && i < 16)
        check("R6 R5 read bit at rising edge", {sdo_oe, sdo}, {1'b1, expd[i-8]});
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      if (rd && !es && i >= 8 && i < 16)
        check("R7 R5 read bit at falling edge", {sdo_oe, sdo}, {1'b1, expd[i-8]});
      sclk = 1'b0;
    end
    repeat (6) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
    in_write = 0;
    if (!rd && nbits >= 16) exp_mem[a] = d;
  endtask

  // {rd, rsvd, addr, data, edge_sel}
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b0, 6'd5,  8'hA5, 1'b1},
    {1'b0, 1'b0, 6'd63, 8'h3C, 1'b0},
    {1'b0, 1'b1, 6'd0,  8'h81, 1'b1},
    {1'b0, 1'b0, 6'd42, 8'hFF, 1'b0},
    {1'b1, 1'b0, 6'd5,  8'h00, 1'b1},
    {1'b1, 1'b0, 6'd63, 8'h00, 1'b0},
    {1'b1, 1'b0, 6'd0,  8'h00, 1'b0},
    {1'b1, 1'b1, 6'd42, 8'h55, 1'b1},
    {1'b1, 1'b0, 6'd17, 8'h00, 1'b1},
    {1'b0, 1'b0, 6'd17, 8'h6E, 1'b0}
  };

  initial begin
    for (int i = 0; i < 64; i++) exp_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check("R12 reset strobes/oe", {we, re, sdo_oe}, 3'b000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 idle after reset", {we, re, sdo_oe}, 3'b000);

    for (int v = 0; v < NV; v++) begin
      int w0, r0;
      w0 = we_cnt; r0 = re_cnt;
      xfer(VEC[v][16], VEC[v][15], VEC[v][14:9], VEC[v][8:1], VEC[v][0], 16);
      if (VEC[v][16]) begin
        check("R4 one read strobe", re_cnt - r0, 1);
        check("R4 no write on read", we_cnt - w0, 0);
      end else begin
        check("R3 one write strobe", we_cnt - w0, 1);
        check("R2 R3 stored byte", mem[VEC[v][14:9]], VEC[v][8:1]);
      end
    end

    // abort after 12 bits
    begin
      int w0;
      w0 = we_cnt;
      xfer(1'b0, 1'b0, 6'd5, 8'h11, 1'b0, 12);
      check("R10 no write on abort", we_cnt - w0, 0);
      check("R10 register untouched", mem[5], 8'hA5);
      // R1: fresh frame after abort counts from zero
      xfer(1'b0, 1'b0, 6'd9, 8'hC3, 1'b1, 16);
      check("R1 restart after abort", mem[9], 8'hC3);
      xfer(1'b1, 1'b0, 6'd5, 8'h00, 1'b1, 16);
    end

    // R11: extra clocks after the 16th bit
    begin
      int w0;
      w0 = we_cnt;
      xfer(1'b0, 1'b0, 6'd20, 8'h9A, 1'b0, 21);
      check("R11 single write with extra clocks", we_cnt - w0, 1);
      check("R11 data of long frame", mem[20], 8'h9A);
      xfer(1'b1, 1'b0, 6'd20, 8'h00, 1'b0, 16);
    end

    check("R9 oe low during writes", oe_bad_wr, 0);
    check("R8 oe low while deselected", oe_bad_cs, 0);

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule